// File: doc/BRIEF.md
# Row-Buffered Dynamic Memory Sequencer

This block models a small dynamic memory array and the sequencer that moves each access through it. Addresses arrive in two halves on one shared bus. A row strobe captures the row half. A column strobe captures the column half some cycles later. Whenever a row is opened, the sequencer decodes it to a one-hot row select and copies the whole row into a bank of column latches. It then writes the latches back into the array, which renews the row's contents. Only after that does it accept the column half, and it either picks one bit out of the latches or replaces one bit in them.

A refresh command carries only a row address. It runs the decode, copy and write-back steps, then returns to idle without producing data. A write follows the same opening steps, replaces the addressed bit inside the latches and writes the row back a second time. The client watches `busy` and waits for the single-cycle `dataValid` pulse. The array is square: the address width sets both the number of rows and the number of columns. The default width of 3 gives 8 rows of 8 bits.

Top module: `dram_row_seq`

## Requirements
- R1: After reset `busy`, `dataValid` and `dataOut` are 0, and every bit of the array reads back as 0.
- R2: A row strobe sampled while idle captures `addr` as the row, and `busy` is high from the next cycle onwards.
- R3: For a read, the column strobe is accepted on the fourth rising edge after the edge that accepted the row strobe. On the next edge `dataValid` rises for exactly one cycle and `busy` falls at the same time.
- R4: Read data is the stored bit whose row index equals the row address value and whose bit position within the row equals the column address value. For example, the 6-bit address 101011 selects row 5, bit 3.
- R5: A column strobe with `writeEn` high stores `writeBit` at the addressed bit. `dataValid` pulses two edges after the column strobe, with `dataOut` equal to the new bit, and the other bits of the row keep their values.
- R6: A row strobe with `refreshCmd` high keeps `busy` high for exactly 3 cycles, produces no `dataValid` pulse and leaves the array contents unchanged.
- R7: A column strobe while idle, with no row open, is ignored: `busy` stays low, no `dataValid` pulse occurs and no bit is written.
- R8: Row strobes arriving while busy are ignored. A column strobe sampled before the row is open is also ignored, so the access in progress keeps its row, column and write data.
- R9: `dataOut` holds its last value between `dataValid` pulses.
- R10: Reads and refreshes write the opened row back unchanged, so stored data persists across any number of accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Shared row/column address bus |
| rowStrobe | input | 1 | Capture row address and start an access |
| colStrobe | input | 1 | Capture column address once the row is open |
| refreshCmd | input | 1 | With rowStrobe: refresh only, no column phase |
| writeEn | input | 1 | With colStrobe: write instead of read |
| writeBit | input | 1 | Bit to store on a write |
| busy | output | 1 | Access in progress |
| dataValid | output | 1 | One-cycle pulse marking a finished read or write |
| dataOut | output | 1 | Bit read or written by the last access |

## Verification
The hardest situation to reach is a stray strobe during the opening steps: a second row strobe and an early column strobe that carries a different address and write bit. Both must land on the few edges before the row is open. The bench steps through each access cycle by cycle on falling edges, and random operations choose whether to inject these intruders at the first step. The later read of the same cell shows that neither one took effect. Refresh and read write-back correctness is shown through a bench copy of the array that every read is compared against, after a random mix of writes, reads and refreshes.

// File: rtl/dram_row_seq_pkg.sv
package dram_row_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SELECT,
    ST_COPY,
    ST_RESTORE,
    ST_WAIT_COL,
    ST_PICK,
    ST_MODIFY,
    ST_COMMIT
  } seqState_t;

  typedef struct packed {
    logic loadRow;
    logic selRow;
    logic copyRow;
    logic writeBack;
    logic loadCol;
    logic modifyBit;
    logic emitData;
  } seqCtrl_t;

endpackage

// File: rtl/dram_row_seq_ctrl.sv
module dram_row_seq_ctrl
  import dram_row_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     rowStrobe,
  input  logic     colStrobe,
  input  logic     refreshCmd,
  input  logic     writeEn,
  output seqCtrl_t ctrl,
  output logic     busy
);

  seqState_t state, stateNext;
  logic      refreshReg;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:     if (rowStrobe) stateNext = ST_SELECT;
      ST_SELECT:   stateNext = ST_COPY;
      ST_COPY:     stateNext = ST_RESTORE;
      ST_RESTORE:  stateNext = refreshReg ? ST_IDLE : ST_WAIT_COL;
      ST_WAIT_COL: if (colStrobe) stateNext = writeEn ? ST_MODIFY : ST_PICK;
      ST_PICK:     stateNext = ST_IDLE;
      ST_MODIFY:   stateNext = ST_COMMIT;
      ST_COMMIT:   stateNext = ST_IDLE;
      default:     stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    ctrl           = '0;
    ctrl.loadRow   = (state == ST_IDLE) && rowStrobe;
    ctrl.selRow    = (state == ST_SELECT);
    ctrl.copyRow   = (state == ST_COPY);
    ctrl.writeBack = (state == ST_RESTORE) || (state == ST_COMMIT);
    ctrl.loadCol   = (state == ST_WAIT_COL) && colStrobe;
    ctrl.modifyBit = (state == ST_MODIFY);
    ctrl.emitData  = (state == ST_PICK) || (state == ST_COMMIT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      refreshReg <= 1'b0;
    end else begin
      state <= stateNext;
      if (ctrl.loadRow) refreshReg <= refreshCmd;
    end
  end

  assign busy = (state != ST_IDLE);

  assert_busy_rise_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(rowStrobe));

  assert_refresh_silent_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RESTORE && refreshReg) |=> (state == ST_IDLE));

  assert_no_emit_refresh_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.emitData && refreshReg));

  assert_col_needs_row_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && colStrobe && !rowStrobe) |=> (state == ST_IDLE));

  assert_row_ignored_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SELECT && rowStrobe) |=> (state == ST_COPY));

endmodule

// File: rtl/dram_row_seq_datapath.sv
module dram_row_seq_datapath
  import dram_row_seq_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtrl_t          ctrl,
  input  logic [ADDR_W-1:0] addr,
  input  logic              writeBit,
  output logic              dataValid,
  output logic              dataOut
);

  localparam int ROWS = 1 << ADDR_W;
  localparam int COLS = 1 << ADDR_W;

  logic [ROWS-1:0][COLS-1:0] cellArray;
  logic [COLS-1:0]           rowLatch;
  logic [COLS-1:0]           sensedRow;
  logic [ROWS-1:0]           rowSel;
  logic [ROWS-1:0]           rowDecode;
  logic [ADDR_W-1:0]         rowReg;
  logic [ADDR_W-1:0]         colReg;
  logic                      wbitReg;

  // row decoder: one line per row
  for (genvar r = 0; r < ROWS; r++) begin : g_dec
    assign rowDecode[r] = (rowReg == ADDR_W'(r));
  end

  // shared sense lines: every row drives through its select gate
  always_comb begin
    sensedRow = '0;
    for (int r = 0; r < ROWS; r++) begin
      sensedRow = sensedRow | (cellArray[r] & {COLS{rowSel[r]}});
    end
  end

  // write-back into whichever row line is selected
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rstN) cellArray[r] <= '0;
      else if (ctrl.writeBack && rowSel[r]) cellArray[r] <= rowLatch;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowReg    <= '0;
      colReg    <= '0;
      wbitReg   <= 1'b0;
      rowSel    <= '0;
      rowLatch  <= '0;
      dataValid <= 1'b0;
      dataOut   <= 1'b0;
    end else begin
      if (ctrl.loadRow) rowReg <= addr;
      if (ctrl.selRow) rowSel <= rowDecode;
      if (ctrl.copyRow) rowLatch <= sensedRow;
      if (ctrl.loadCol) begin
        colReg  <= addr;
        wbitReg <= writeBit;
      end
      if (ctrl.modifyBit) rowLatch[colReg] <= wbitReg;
      dataValid <= ctrl.emitData;
      if (ctrl.emitData) dataOut <= rowLatch[colReg];
    end
  end

  assert_copy_row_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.copyRow |=> (rowLatch == $past(cellArray[rowReg])));

  assert_writeback_R10: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.writeBack |=> (cellArray[$past(rowReg)] == $past(rowLatch)));

  assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> !dataValid);

  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !dataValid |-> $stable(dataOut));

endmodule

// File: rtl/dram_row_seq.sv
module dram_row_seq
  import dram_row_seq_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rowStrobe,
  input  logic              colStrobe,
  input  logic              refreshCmd,
  input  logic              writeEn,
  input  logic              writeBit,
  output logic              busy,
  output logic              dataValid,
  output logic              dataOut
);

  seqCtrl_t ctrl;

  dram_row_seq_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .rowStrobe  (rowStrobe),
    .colStrobe  (colStrobe),
    .refreshCmd (refreshCmd),
    .writeEn    (writeEn),
    .ctrl       (ctrl),
    .busy       (busy)
  );

  dram_row_seq_datapath #(.ADDR_W(ADDR_W)) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .addr      (addr),
    .writeBit  (writeBit),
    .dataValid (dataValid),
    .dataOut   (dataOut)
  );

  assert_busy_ends_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataValid) |-> !busy);

endmodule

// File: tb/test_dram_row_seq.sv
module test_dram_row_seq;

  localparam int AW = 3;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          rowStrobe = 1'b0;
  logic          colStrobe = 1'b0;
  logic          refreshCmd = 1'b0;
  logic          writeEn = 1'b0;
  logic          writeBit = 1'b0;
  logic          busy, dataValid, dataOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [N-1:0][N-1:0] model;
  logic lastOut;

  always #5 clk = ~clk;

  dram_row_seq #(.ADDR_W(AW)) i_dram_row_seq (
    .clk(clk), .rstN(rstN), .addr(addr), .rowStrobe(rowStrobe),
    .colStrobe(colStrobe), .refreshCmd(refreshCmd), .writeEn(writeEn),
    .writeBit(writeBit), .busy(busy), .dataValid(dataValid), .dataOut(dataOut)
  );

  function automatic logic expBit(input int row, input int col);
    return model[row][col];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // kind: 0 read, 1 write, 2 refresh
  task automatic doOp(input int kind, input int row, input int col, input logic wb,
                      input bit earlyCol, input bit intrude);
    @(negedge clk);
    addr = AW'(row); rowStrobe = 1'b1; refreshCmd = (kind == 2);
    @(negedge clk);                           // after accepting edge
    rowStrobe = 1'b0; refreshCmd = 1'b0;
    chk("R2 busy after row strobe", busy, 1);
    if (earlyCol) begin
      colStrobe = 1'b1; addr = AW'(~col); writeEn = 1'b1; writeBit = ~wb;
    end
    if (intrude) begin
      rowStrobe = 1'b1; addr = AW'(row ^ 1);
    end
    @(negedge clk);                           // after edge 1
    colStrobe = 1'b0; rowStrobe = 1'b0; writeEn = 1'b0;
    @(negedge clk);                           // after edge 2
    if (kind == 2) chk("R6 no valid in refresh", dataValid, 0);
    @(negedge clk);                           // after edge 3
    if (kind == 2) begin
      chk("R6 busy ends after 3 cycles", busy, 0);
      chk("R6 no valid pulse", dataValid, 0);
      return;
    end
    chk("R8 busy while row open", busy, 1);
    colStrobe = 1'b1; addr = AW'(col); writeEn = (kind == 1); writeBit = wb;
    @(negedge clk);                           // after edge 4
    colStrobe = 1'b0; writeEn = 1'b0;
    chk("R3 no early valid", dataValid, 0);
    if (kind == 1) begin
      model[row][col] = wb;
      @(negedge clk);
      chk("R5 busy during commit", busy, 1);
      chk("R5 no valid yet", dataValid, 0);
      @(negedge clk);
      chk("R5 write valid", dataValid, 1);
      chk("R5 written bit", dataOut, wb);
    end else begin
      @(negedge clk);
      chk("R3 read valid", dataValid, 1);
      chk("R4 read data", dataOut, expBit(row, col));
    end
    chk("R3 busy falls with valid", busy, 0);
    lastOut = dataOut;
    @(negedge clk);
    chk("R3 valid one cycle", dataValid, 0);
    chk("R9 output held", dataOut, lastOut);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_d1a7));
    model = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 busy reset", busy, 0);
    chk("R1 valid reset", dataValid, 0);
    chk("R1 dataOut reset", dataOut, 0);
    for (int r = 0; r < N; r++) doOp(0, r, (r * 3) % N, 1'b0, 0, 0); // R1 zero array

    // R4: address 101011 -> row 5, bit 3
    doOp(1, 5, 3, 1'b1, 0, 0);
    doOp(0, 5, 3, 1'b0, 0, 0);
    doOp(0, 3, 5, 1'b0, 0, 0);
    doOp(0, 5, 2, 1'b0, 0, 0);   // R5 neighbour untouched

    // R7: column strobe while idle
    @(negedge clk);
    colStrobe = 1'b1; writeEn = 1'b1; writeBit = 1'b1; addr = 3'd2;
    @(negedge clk);
    colStrobe = 1'b0; writeEn = 1'b0;
    chk("R7 idle col strobe busy", busy, 0);
    @(negedge clk);
    chk("R7 idle col strobe valid", dataValid, 0);
    doOp(0, 0, 2, 1'b0, 0, 0);   // R7 no bit written at row 0 bit 2

    // R8: intruders during opening steps
    doOp(1, 6, 1, 1'b1, 1, 1);
    doOp(0, 6, 1, 1'b0, 1, 1);
    doOp(0, 7, 1, 1'b0, 0, 0);
    doOp(0, 6, 6, 1'b0, 0, 0);

    // R6 / R10: refresh keeps data
    doOp(2, 5, 0, 1'b0, 0, 0);
    doOp(0, 5, 3, 1'b0, 0, 0);

    for (int i = 0; i < 300; i++) begin
      int k = $urandom_range(0, 2);
      doOp(k, $urandom_range(0, N-1), $urandom_range(0, N-1), 1'($urandom),
           ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0));
    end
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) doOp(0, r, c, 1'b0, 0, 0); // R10 full sweep

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule